// File: doc/BRIEF.md
# In-Order Store Buffer

This block is a queue of issued stores. Issue never has to wait because a store missed the cache; the store is simply written into the queue. Each entry records an address, 64-bit data, a byte mask, a destination class and a miss flag. The head entry is presented on one of three write ports:

- cacheable memory,
- the noncacheable bus,
- internal register space.

Each port has its own valid and ready. All three ports share one address, data and mask bus.

Entries leave in exactly the order they were issued. When the head is a cacheable store that missed, it stays at the head until the fill-done pulse arrives. Every younger store waits behind it, including cache hits and stores bound for the other ports.

The block has two status outputs. The full flag back-pressures issue only when every slot is occupied. The empty flag lets barrier logic wait for the queue to drain.

Top module: `store_order_queue`

## Requirements
- R1: While reset is low and right after it, `empty` is 1, `full` is 0, and all three port valids are 0.
- R2: A store is taken when `issueValid` is high and `full` is low. `full` is 1 exactly when DEPTH entries are held. An issue made while `full` is 1 is dropped and never appears on any port.
- R3: Stores appear on the write ports in issue order, each with the address, data and mask it was issued with.
- R4: The head entry is routed by its class. Class 0 goes to the cacheable port, class 1 to the bus port, and classes 2 and 3 to the register port. At most one port valid is high in any cycle.
- R5: The head entry is removed on the cycle its port has valid and ready both high. Until then it stays on the shared outputs unchanged.
- R6: A class-0 head whose miss flag is set raises no valid until a `fillDone` pulse has been seen while it is the head. The cacheable valid rises on the cycle after that pulse.
- R7: Younger entries, including class-0 hits, are not presented while an older miss waits at the head.
- R8: A `fillDone` pulse is ignored when the head is not a waiting class-0 miss, or when the queue is empty. It does not release a later miss.
- R9: A store taken and a store removed in the same cycle leave the occupancy unchanged.
- R10: `empty` is 1 exactly when no entry is held. When `empty` is 1, no port valid is high.
- R11: The miss flag has no effect on class 1, 2 or 3 entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | Store issued this cycle |
| issueClass | input | 2 | Destination class (0 cache, 1 bus, 2/3 register) |
| issueMiss | input | 1 | Store missed the cache (meaningful for class 0) |
| issueAddr | input | AW | Store address |
| issueData | input | DW | Store data |
| issueMask | input | MW | Byte mask |
| full | output | 1 | All slots occupied; issue must hold |
| empty | output | 1 | No store held |
| fillDone | input | 1 | Fill for the missing line has completed |
| cacheValid | output | 1 | Head valid on the cacheable port |
| cacheReady | input | 1 | Cacheable port accepts |
| busValid | output | 1 | Head valid on the noncacheable bus port |
| busReady | input | 1 | Bus port accepts |
| regValid | output | 1 | Head valid on the internal register port |
| regReady | input | 1 | Register port accepts |
| wrAddr | output | AW | Head address |
| wrData | output | DW | Head data |
| wrMask | output | MW | Head byte mask |

## Verification
The bench drives long streams with mixed classes, miss flags, fill pulses and ready patterns against an arithmetic queue model.

It aims at these corner cases:

- **Issue while full.** A design that takes an issue while full would overwrite an entry and present data out of order.
- **Miss blocking younger stores.** A design that lets a younger hit overtake a waiting miss would show a younger address early on the cache or bus port.
- **Fill pulse at the wrong time.** A fill pulse that arrives while a bus store is at the head must not be remembered. Remembering it would release the later miss before its own fill.
- **Simultaneous take and remove.** Taking and removing a store in the same cycle at seven entries must keep `full` low. A design that counts this wrongly would either raise `full` early or lose a slot.

// File: rtl/sq_pkg.sv
package sq_pkg;

  typedef enum logic [1:0] {
    DST_CACHE   = 2'd0,
    DST_BUS     = 2'd1,
    DST_REG     = 2'd2,
    DST_REG_ALT = 2'd3
  } sqDest_e;

  typedef struct packed {
    logic push;
    logic pop;
  } sqStrobe_t;

endpackage

// File: rtl/sq_datapath.sv
module sq_datapath
  import sq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 64,
  parameter int MW    = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  sqStrobe_t     strb,
  input  logic [1:0]    inClass,
  input  logic          inMiss,
  input  logic [AW-1:0] inAddr,
  input  logic [DW-1:0] inData,
  input  logic [MW-1:0] inMask,
  output logic [1:0]    headClass,
  output logic          headMiss,
  output logic [AW-1:0] headAddr,
  output logic [DW-1:0] headData,
  output logic [MW-1:0] headMask
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [PW-1:0] wrPtr, rdPtr;
  logic [1:0]    slotClass [DEPTH];
  logic          slotMiss  [DEPTH];
  logic [AW-1:0] slotAddr  [DEPTH];
  logic [DW-1:0] slotData  [DEPTH];
  logic [MW-1:0] slotMask  [DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strb.push) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (strb.pop)  rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : gSlot
    always_ff @(posedge clk) begin
      if (strb.push && wrPtr == PW'(i)) begin
        slotClass[i] <= inClass;
        slotMiss[i]  <= inMiss;
        slotAddr[i]  <= inAddr;
        slotData[i]  <= inData;
        slotMask[i]  <= inMask;
      end
    end
  end

  assign headClass = slotClass[rdPtr];
  assign headMiss  = slotMiss[rdPtr];
  assign headAddr  = slotAddr[rdPtr];
  assign headData  = slotData[rdPtr];
  assign headMask  = slotMask[rdPtr];

endmodule

// File: rtl/sq_control.sv
module sq_control
  import sq_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       issueValid,
  input  logic [1:0] headClass,
  input  logic       headMiss,
  input  logic       fillDone,
  input  logic       cacheReady,
  input  logic       busReady,
  input  logic       regReady,
  output sqStrobe_t  strb,
  output logic       full,
  output logic       empty,
  output logic       cacheValid,
  output logic       busValid,
  output logic       regValid
);

  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] count;
  logic          fillSeen;
  logic          headLive, headIsMiss, waitFill;

  assign headLive   = (count != '0);
  assign headIsMiss = (headClass == DST_CACHE) && headMiss;
  assign waitFill   = headIsMiss && !fillSeen;

  assign cacheValid = headLive && (headClass == DST_CACHE) && !waitFill;
  assign busValid   = headLive && (headClass == DST_BUS);
  assign regValid   = headLive && headClass[1];

  assign full  = (count == CW'(DEPTH));
  assign empty = !headLive;

  assign strb.push = issueValid && !full;
  assign strb.pop  = (cacheValid && cacheReady) || (busValid && busReady) ||
                     (regValid && regReady);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count    <= '0;
      fillSeen <= 1'b0;
    end else begin
      case ({strb.push, strb.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (strb.pop)
        fillSeen <= 1'b0;
      else if (fillDone && headLive && headIsMiss)
        fillSeen <= 1'b1;
    end
  end

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    full && issueValid && !strb.pop |=> full);

  // R4
  one_port_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cacheValid, busValid, regValid}));

  // R6
  miss_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cacheValid) && headMiss |-> $past(fillDone));

  // R10
  empty_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    empty |-> !(cacheValid || busValid || regValid));

endmodule

// File: rtl/store_order_queue.sv
module store_order_queue
  import sq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 64,
  parameter int MW    = DW / 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          issueValid,
  input  logic [1:0]    issueClass,
  input  logic          issueMiss,
  input  logic [AW-1:0] issueAddr,
  input  logic [DW-1:0] issueData,
  input  logic [MW-1:0] issueMask,
  output logic          full,
  output logic          empty,
  input  logic          fillDone,
  output logic          cacheValid,
  input  logic          cacheReady,
  output logic          busValid,
  input  logic          busReady,
  output logic          regValid,
  input  logic          regReady,
  output logic [AW-1:0] wrAddr,
  output logic [DW-1:0] wrData,
  output logic [MW-1:0] wrMask
);

  sqStrobe_t  strb;
  logic [1:0] headClass;
  logic       headMiss;

  sq_control #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .issueValid(issueValid),
    .headClass(headClass), .headMiss(headMiss), .fillDone(fillDone),
    .cacheReady(cacheReady), .busReady(busReady), .regReady(regReady),
    .strb(strb), .full(full), .empty(empty),
    .cacheValid(cacheValid), .busValid(busValid), .regValid(regValid)
  );

  sq_datapath #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .MW(MW)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb),
    .inClass(issueClass), .inMiss(issueMiss), .inAddr(issueAddr),
    .inData(issueData), .inMask(issueMask),
    .headClass(headClass), .headMiss(headMiss),
    .headAddr(wrAddr), .headData(wrData), .headMask(wrMask)
  );

  // R5
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cacheValid && !cacheReady) || (busValid && !busReady) || (regValid && !regReady)
    |=> $stable(wrAddr) && $stable(wrData) && $stable(wrMask));

endmodule

// File: tb/store_order_queue_tb.sv
module store_order_queue_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int AW = 32;
  localparam int DW = 64;
  localparam int MW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic issueValid = 1'b0, issueMiss = 1'b0, fillDone = 1'b0;
  logic [1:0] issueClass = '0;
  logic [AW-1:0] issueAddr = '0;
  logic [DW-1:0] issueData = '0;
  logic [MW-1:0] issueMask = '0;
  logic cacheReady = 1'b0, busReady = 1'b0, regReady = 1'b0;
  logic full, empty, cacheValid, busValid, regValid;
  logic [AW-1:0] wrAddr;
  logic [DW-1:0] wrData;
  logic [MW-1:0] wrMask;

  int compared = 0;
  int mismatched = 0;

  int mCls [64];
  bit mMiss [64];
  int mSeq [64];
  int mHead = 0, mTail = 0, mCnt = 0;
  bit mFill = 1'b0;
  int seqNo = 1;

  always #(CLK_PERIOD / 2) clk = ~clk;

  store_order_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .MW(MW)) u_dut (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueClass(issueClass),
    .issueMiss(issueMiss), .issueAddr(issueAddr), .issueData(issueData),
    .issueMask(issueMask), .full(full), .empty(empty), .fillDone(fillDone),
    .cacheValid(cacheValid), .cacheReady(cacheReady), .busValid(busValid),
    .busReady(busReady), .regValid(regValid), .regReady(regReady),
    .wrAddr(wrAddr), .wrData(wrData), .wrMask(wrMask)
  );

  function automatic logic [AW-1:0] addrOf(int s);
    return AW'(s * 8 + 32'h100);
  endfunction
  function automatic logic [DW-1:0] dataOf(int s);
    return {32'(s) * 32'h9E37, ~32'(s)};
  endfunction
  function automatic logic [MW-1:0] maskOf(int s);
    return MW'(s * 3 + 1);
  endfunction

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(bit iv, int cls, bit miss, bit fd, bit [2:0] rdy);
    bit exC, exB, exR, deq, acc;
    int c;
    @(negedge clk);
    issueValid = iv; issueClass = cls[1:0]; issueMiss = miss;
    issueAddr = addrOf(seqNo); issueData = dataOf(seqNo); issueMask = maskOf(seqNo);
    fillDone = fd;
    {regReady, busReady, cacheReady} = rdy;
    #1;
    exC = 0; exB = 0; exR = 0;
    if (mCnt > 0) begin
      c = mCls[mHead];
      if (c == 0) exC = !(mMiss[mHead] && !mFill);
      else if (c == 1) exB = 1;   // R11: miss flag ignored off class 0
      else exR = 1;
    end
    chk("R2", DW'(full), DW'(mCnt == DEPTH));
    chk("R10", DW'(empty), DW'(mCnt == 0));
    chk((mCnt > 0 && mCls[mHead] == 0 && mMiss[mHead]) ? "R6" : "R4", DW'(cacheValid), DW'(exC));
    chk("R4", DW'(busValid), DW'(exB));
    chk("R4", DW'(regValid), DW'(exR));
    if (exC || exB || exR) begin
      chk("R3", DW'(wrAddr), DW'(addrOf(mSeq[mHead])));
      chk("R3", wrData, dataOf(mSeq[mHead]));
      chk("R3", DW'(wrMask), DW'(maskOf(mSeq[mHead])));
    end
    deq = (exC && rdy[0]) || (exB && rdy[1]) || (exR && rdy[2]);
    acc = iv && (mCnt < DEPTH);
    if (deq) mFill = 0;
    else if (fd && mCnt > 0 && mCls[mHead] == 0 && mMiss[mHead]) mFill = 1;
    if (deq) begin mHead = (mHead + 1) % 64; mCnt--; end
    if (acc) begin
      mCls[mTail] = cls; mMiss[mTail] = miss; mSeq[mTail] = seqNo;
      mTail = (mTail + 1) % 64; mCnt++;
    end
    if (iv) seqNo++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1", DW'(empty), 64'd1);
    chk("R1", DW'(full), 64'd0);
    chk("R1", DW'({cacheValid, busValid, regValid}), 64'd0);
    rstN = 1'b1;

    // R2: fill past depth with ports stalled, then drain
    for (int i = 0; i < DEPTH + 2; i++) tick(1, i % 4, 0, 0, 3'b000);
    for (int i = 0; i < DEPTH + 2; i++) tick(0, 0, 0, 0, 3'b111);

    // R6, R7: miss at head holds younger hit and bus store
    tick(1, 0, 1, 0, 3'b111);
    tick(1, 0, 0, 0, 3'b111);
    tick(1, 1, 0, 0, 3'b111);
    for (int i = 0; i < 4; i++) begin
      tick(0, 0, 0, 0, 3'b111);
      chk("R7", DW'({cacheValid, busValid, regValid}), 64'd0);
    end
    tick(0, 0, 0, 1, 3'b111);
    for (int i = 0; i < 4; i++) tick(0, 0, 0, 0, 3'b111);

    // R8, R11: fill pulse while bus store heads the queue is dropped
    tick(1, 1, 1, 0, 3'b000);
    tick(1, 0, 1, 0, 3'b000);
    tick(0, 0, 0, 1, 3'b000);
    tick(0, 0, 0, 0, 3'b010);
    for (int i = 0; i < 3; i++) begin
      tick(0, 0, 0, 0, 3'b111);
      chk("R8", DW'(cacheValid), 64'd0);
    end
    tick(0, 0, 0, 1, 3'b111);
    tick(0, 0, 0, 0, 3'b111);
    tick(0, 0, 0, 1, 3'b111);   // R8: fill on empty queue
    tick(1, 0, 1, 0, 3'b111);
    tick(0, 0, 0, 0, 3'b111);
    chk("R8", DW'(cacheValid), 64'd0);
    tick(0, 0, 0, 1, 3'b111);
    tick(0, 0, 0, 0, 3'b111);

    // R9: at DEPTH-1 entries, take and remove together
    for (int i = 0; i < DEPTH - 1; i++) tick(1, 1 + i % 3, 0, 0, 3'b000);
    for (int i = 0; i < 6; i++) begin
      tick(1, 2, 0, 0, 3'b111);
      if (i > 0) chk("R9", DW'({full, empty}), 64'd0);
    end
    tick(1, 1, 0, 0, 3'b000);
    tick(0, 0, 0, 0, 3'b000);
    chk("R9", DW'(full), 64'd1);
    for (int i = 0; i < DEPTH + 2; i++) tick(0, 0, 0, 0, 3'b111);

    // R3, R5: mixed sweep of classes, misses, fills and readies
    for (int i = 0; i < 400; i++)
      tick((i % 7) != 3, (i * 5) % 4, (i % 5) == 0, (i % 3) == 0, 3'((i * 7 + i / 9) % 8));
    for (int i = 0; i < 40; i++) tick(0, 0, 0, (i % 2) == 0, 3'b111);
    chk("R10", DW'(empty), 64'd1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule